// File: doc/BRIEF.md
# USB Device Controller Register Bank with Three Reset Sources

This block holds the 16-bit control and status words of a full-speed USB device controller. A CPU reaches it through a 16-bit data bus with a 7-bit byte address. Registers sit on even byte addresses, and address bit 0 is ignored. Stored fields are driven out as ports to the rest of the controller. Read-only fields come in as ports from the logic that owns them, which includes the interrupt status, the captured setup request and the FIFO flags.

Three reset sources act on the stored registers, and each source is applied per register. The first is a synchronous hardware reset input, which has the highest priority. The second is a software reset that stays active for as long as the enable bit is clear. The third is a one-cycle pulse that reports a detected USB bus reset. For each source, a register either loads its defined value or keeps what it holds. Any address not listed below is reserved: it ignores writes and reads as zero.

Address map, by byte address:
- 00h: enable. Bit 0 is stored and read-write.
- 02h: wake. Bit 0 is stored and read-write.
- 04h: device address. Bits 6:0 are stored and read-write.
- 08h: interrupt enable. All 16 bits are stored and read-write.
- 0Ah: interrupt status. This word is read-only and comes from `stat_in`.
- 0Ch: EP0 packet size. Bits 6:0 are stored and read-write.
- 0Eh: FIFO control. Bits 15:12 are read-only and come from `fifo_flags`. Bits 11:0 are stored and read-write.
- 20h + 4·i: configuration word 0 of endpoint i. All 16 bits are read-write.
- 22h + 4·i: configuration word 1 of endpoint i. All 16 bits are read-write.
- 30h: setup request. This word is read-only and comes from `setup_in`.

Top module: `usb_reg_bank`

## Requirements
- R1: After hardware reset the registers take these values: enable, wake, device address, interrupt enable and every configuration word 0 read 0000h; the EP0 packet size reads 0008h; FIFO control bits 11:0 read 800h; every configuration word 1 reads 0040h.
- R2: When hardware reset is high in a cycle, it takes precedence over a bus reset and over a CPU write in that same cycle. The reset values of R1 result.
- R3: While the enable bit is 0, the following are held at their reset values and CPU writes to them are ignored: wake, device address, interrupt enable, and FIFO control bits 11:0. The values apply one cycle after the bit clears. The enable bit is not affected by this software reset.
- R4: The software reset does not touch the EP0 packet size or the endpoint configuration words. These accept writes and keep their values while the enable bit is 0.
- R5: A bus reset pulse clears the device address and every configuration word 0. All other stored registers keep their values.
- R6: A bus reset in the same cycle as a write to the device address or to a configuration word 0 wins, and the register reads 0000h afterwards.
- R7: Words 0Ah and 30h read `stat_in` and `setup_in` directly. Writes to them change nothing.
- R8: At 0Eh, bits 15:12 always read `fifo_flags`. A write there updates only bits 11:0.
- R9: Bits outside the stored field of a narrow register (enable, wake, device address, packet size) read as 0. Writes to those bits are ignored.
- R10: A write to a reserved address leaves every register unchanged. A read from a reserved address returns 0000h.
- R11: With `cs` low, no write takes place and `rdata` is 0000h. Address bit 0 is ignored on both reads and writes.
- R12: A value written to a read-write field reads back from the next cycle on. Each register is independent of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Hardware reset, synchronous, active high, highest priority |
| bus_rst | input | 1 | One-cycle pulse for a detected USB bus reset |
| cs | input | 1 | Bus select |
| we | input | 1 | Write strobe, valid with `cs` |
| addr | input | 7 | Byte address; bit 0 ignored |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| stat_in | input | 16 | Interrupt status word, read-only at 0Ah |
| setup_in | input | 16 | Setup request word, read-only at 30h |
| fifo_flags | input | 4 | FIFO flags, read-only at 0Eh bits 15:12 |
| usb_en | output | 1 | Enable bit; 0 holds the software reset |
| wake | output | 1 | Remote wake request |
| dev_addr | output | 7 | Device address |
| irq_en | output | 16 | Interrupt enable mask |
| ep0_size | output | 7 | EP0 maximum packet size |
| fifo_ctl | output | 12 | FIFO control field |
| ep_cfg0 | output | 16·NEP | Configuration word 0 of each endpoint, endpoint 0 in the low bits |
| ep_cfg1 | output | 16·NEP | Configuration word 1 of each endpoint |

## Verification
The bench sweeps all 64 word addresses. It writes a per-address pattern to every read-write word and all ones to every reserved word, then reads the whole map back. A decoder that aliased a reserved word onto a real register would show a corrupted value, and a missing mask would expose bits that should read as zero. The bench also collides resets with writes. A bank that let a write beat a bus or hardware reset, or that let a bus reset clear registers it should leave alone, would read back the wrong value. Finally, the bench clears the enable bit and checks that only the software-reset set collapses while the packet size and endpoint words survive. A design that reset the enable bit with itself, or that reset the wrong group, fails this check.

// File: rtl/usb_reg_bank.sv
module usb_reg_bank #(
  parameter int          NEP      = 3,
  parameter logic [6:0]  SIZE_RST = 7'h08,
  parameter logic [11:0] FIFO_RST = 12'h800,
  parameter logic [15:0] CFG1_RST = 16'h0040
) (
  input  logic                clk,
  input  logic                hw_rst,
  input  logic                bus_rst,
  input  logic                cs,
  input  logic                we,
  input  logic [6:0]          addr,
  input  logic [15:0]         wdata,
  output logic [15:0]         rdata,
  input  logic [15:0]         stat_in,
  input  logic [15:0]         setup_in,
  input  logic [3:0]          fifo_flags,
  output logic                usb_en,
  output logic                wake,
  output logic [6:0]          dev_addr,
  output logic [15:0]         irq_en,
  output logic [6:0]          ep0_size,
  output logic [11:0]         fifo_ctl,
  output logic [16*NEP-1:0]   ep_cfg0,
  output logic [16*NEP-1:0]   ep_cfg1
);
  localparam logic [5:0] W_EN    = 6'h00;
  localparam logic [5:0] W_WAKE  = 6'h01;
  localparam logic [5:0] W_DEV   = 6'h02;
  localparam logic [5:0] W_IRQ   = 6'h04;
  localparam logic [5:0] W_STAT  = 6'h05;
  localparam logic [5:0] W_SIZE  = 6'h06;
  localparam logic [5:0] W_FIFO  = 6'h07;
  localparam logic [5:0] W_EP    = 6'h10;
  localparam logic [5:0] W_SETUP = 6'h18;

  logic [5:0]  wa;
  logic        wr, sw_rst;
  logic [15:0] rd;

  assign wa     = addr[6:1];
  assign wr     = cs & we;
  assign sw_rst = ~usb_en;

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      usb_en   <= 1'b0;
      wake     <= 1'b0;
      dev_addr <= '0;
      irq_en   <= '0;
      ep0_size <= SIZE_RST;
      fifo_ctl <= FIFO_RST;
    end else begin
      if (wr && wa == W_EN) usb_en <= wdata[0];

      if (sw_rst) wake <= 1'b0;
      else if (wr && wa == W_WAKE) wake <= wdata[0];

      if (sw_rst || bus_rst) dev_addr <= '0;
      else if (wr && wa == W_DEV) dev_addr <= wdata[6:0];

      if (sw_rst) irq_en <= '0;
      else if (wr && wa == W_IRQ) irq_en <= wdata;

      if (wr && wa == W_SIZE) ep0_size <= wdata[6:0];

      if (sw_rst) fifo_ctl <= FIFO_RST;
      else if (wr && wa == W_FIFO) fifo_ctl <= wdata[11:0];
    end
  end

  for (genvar i = 0; i < NEP; i++) begin : g_ep
    localparam logic [5:0] WC0 = 6'(W_EP + 2*i);
    localparam logic [5:0] WC1 = 6'(W_EP + 2*i + 1);
    logic [15:0] c0_q, c1_q;
    always_ff @(posedge clk) begin
      if (hw_rst) begin
        c0_q <= '0;
        c1_q <= CFG1_RST;
      end else begin
        if (bus_rst) c0_q <= '0;
        else if (wr && wa == WC0) c0_q <= wdata;
        if (wr && wa == WC1) c1_q <= wdata;
      end
    end
    assign ep_cfg0[16*i +: 16] = c0_q;
    assign ep_cfg1[16*i +: 16] = c1_q;
  end

  always_comb begin
    case (wa)
      W_EN:    rd = {15'b0, usb_en};
      W_WAKE:  rd = {15'b0, wake};
      W_DEV:   rd = {9'b0, dev_addr};
      W_IRQ:   rd = irq_en;
      W_STAT:  rd = stat_in;
      W_SIZE:  rd = {9'b0, ep0_size};
      W_FIFO:  rd = {fifo_flags, fifo_ctl};
      W_SETUP: rd = setup_in;
      default: rd = '0;
    endcase
    for (int i = 0; i < NEP; i++) begin
      if (wa == 6'(W_EP + 2*i))     rd = ep_cfg0[16*i +: 16];
      if (wa == 6'(W_EP + 2*i + 1)) rd = ep_cfg1[16*i +: 16];
    end
  end

  assign rdata = cs ? rd : 16'h0000;
endmodule

// File: rtl/usb_reg_bank_chk.sv
module usb_reg_bank_chk #(
  parameter int NEP = 3
) (
  input logic              clk,
  input logic              hw_rst,
  input logic              bus_rst,
  input logic              cs,
  input logic              we,
  input logic [6:0]        addr,
  input logic [15:0]       rdata,
  input logic [3:0]        fifo_flags,
  input logic              usb_en,
  input logic              wake,
  input logic [6:0]        dev_addr,
  input logic [15:0]       irq_en,
  input logic [6:0]        ep0_size,
  input logic [11:0]       fifo_ctl,
  input logic [16*NEP-1:0] ep_cfg0,
  input logic [16*NEP-1:0] ep_cfg1
);
  function automatic logic is_mapped(input logic [5:0] w);
    return (w <= 6'd7 && w != 6'd3) || (int'(w) >= 16 && int'(w) < 16 + 2*NEP) || w == 6'd24;
  endfunction

  logic rsv;
  assign rsv = ~is_mapped(addr[6:1]);

  assert_hw_defaults_R1: assert property (@(posedge clk) disable iff (hw_rst)
    $fell(hw_rst) |-> (!usb_en && !wake && dev_addr == 7'd0 && irq_en == 16'd0 &&
                       ep0_size == 7'h08 && fifo_ctl == 12'h800 && ep_cfg0 == '0));

  assert_sw_hold_R3: assert property (@(posedge clk) disable iff (hw_rst)
    !usb_en |=> (!wake && dev_addr == 7'd0 && irq_en == 16'd0 && fifo_ctl == 12'h800));

  assert_bus_clear_R5: assert property (@(posedge clk) disable iff (hw_rst)
    bus_rst |=> (dev_addr == 7'd0 && ep_cfg0 == '0));

  assert_fifo_flags_R8: assert property (@(posedge clk) disable iff (hw_rst)
    (cs && addr[6:1] == 6'd7) |-> rdata[15:12] == fifo_flags);

  assert_rsv_read_R10: assert property (@(posedge clk) disable iff (hw_rst)
    (cs && rsv) |-> rdata == 16'h0000);

  assert_rsv_write_R10: assert property (@(posedge clk) disable iff (hw_rst)
    (cs && we && rsv && !bus_rst && usb_en) |=>
      $stable({usb_en, wake, dev_addr, irq_en, ep0_size, fifo_ctl, ep_cfg0, ep_cfg1}));

  assert_idle_read_R11: assert property (@(posedge clk) disable iff (hw_rst)
    !cs |-> rdata == 16'h0000);
endmodule

bind usb_reg_bank usb_reg_bank_chk #(.NEP(NEP)) u_chk (.*);

// File: tb/usb_reg_bank_test.sv
module usb_reg_bank_test;
  logic clk = 1'b0;
  logic hw_rst = 1'b1, bus_rst = 1'b0, cs = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0, stat_in = '0, setup_in = '0;
  logic [3:0]  fifo_flags = '0;
  logic [15:0] rdata, irq_en;
  logic        usb_en, wake;
  logic [6:0]  dev_addr, ep0_size;
  logic [11:0] fifo_ctl;
  logic [47:0] ep_cfg0, ep_cfg1;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  usb_reg_bank uut (.clk(clk), .hw_rst(hw_rst), .bus_rst(bus_rst), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .stat_in(stat_in), .setup_in(setup_in),
    .fifo_flags(fifo_flags), .usb_en(usb_en), .wake(wake), .dev_addr(dev_addr),
    .irq_en(irq_en), .ep0_size(ep0_size), .fifo_ctl(fifo_ctl),
    .ep_cfg0(ep_cfg0), .ep_cfg1(ep_cfg1));

  function automatic logic [15:0] pat(input int a);
    return 16'hA5C3 ^ (16'(a) * 16'h0101);
  endfunction

  function automatic logic [15:0] rw_mask(input int a);
    if (a == 'h02) return 16'h0001;
    if (a == 'h04 || a == 'h0C) return 16'h007F;
    if (a == 'h08 || (a >= 'h20 && a <= 'h2A)) return 16'hFFFF;
    if (a == 'h0E) return 16'h0FFF;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] sweep_exp(input int a);
    if (a == 'h00) return 16'h0001;
    if (a == 'h0A) return stat_in;
    if (a == 'h30) return setup_in;
    if (a == 'h0E) return {fifo_flags, pat(a)[11:0]};
    return pat(a) & rw_mask(a);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string req);
    cs = 1'b1; we = 1'b0; addr = a; #1;
    chk(req, rdata, exp);
    cs = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    hw_rst = 1'b0;
    // R1 reset state
    rd(7'h00, 16'h0000, "R1"); rd(7'h04, 16'h0000, "R1"); rd(7'h08, 16'h0000, "R1");
    rd(7'h0C, 16'h0008, "R1"); rd(7'h0E, 16'h0800, "R1");
    for (int i = 0; i < 3; i++) begin
      rd(7'(32 + 4*i), 16'h0000, "R1");
      rd(7'(34 + 4*i), 16'h0040, "R1");
    end
    chk("R1", {15'b0, usb_en}, 16'h0000);

    // R3 writes blocked while disabled
    wr(7'h08, 16'hFFFF); rd(7'h08, 16'h0000, "R3");
    wr(7'h04, 16'h007F); rd(7'h04, 16'h0000, "R3");
    wr(7'h02, 16'h0001); rd(7'h02, 16'h0000, "R3");
    wr(7'h0E, 16'h0123); rd(7'h0E, 16'h0800, "R3");
    // R4 keep-type registers writable while disabled
    wr(7'h0C, 16'h00D5); rd(7'h0C, 16'h0055, "R4");
    wr(7'h20, 16'h1111); rd(7'h20, 16'h1111, "R4");
    wr(7'h22, 16'h2222); rd(7'h22, 16'h2222, "R4");

    wr(7'h00, 16'h0001); rd(7'h00, 16'h0001, "R12");
    wr(7'h00, 16'hFFFF); rd(7'h00, 16'h0001, "R9");

    // R12 / R10 / R9 sweep
    stat_in = 16'h3C5A; setup_in = 16'h8001; fifo_flags = 4'h6;
    for (int a = 2; a < 128; a += 2) begin
      if (a == 'h0A || a == 'h30) continue;
      if (rw_mask(a) != 16'h0000) wr(7'(a), pat(a));
      else wr(7'(a), 16'hFFFF);
    end
    for (int a = 0; a < 128; a += 2) begin
      if (rw_mask(a) != 16'h0000) rd(7'(a), sweep_exp(a), "R12");
      else if (a == 'h00 || a == 'h0A || a == 'h30) rd(7'(a), sweep_exp(a), "R7");
      else rd(7'(a), 16'h0000, "R10");
    end

    // R7 read-only words
    wr(7'h0A, 16'h0000); rd(7'h0A, 16'h3C5A, "R7");
    wr(7'h30, 16'h0000); rd(7'h30, 16'h8001, "R7");
    // R8 mixed word
    fifo_flags = 4'hA;
    wr(7'h0E, 16'h5ABC); rd(7'h0E, 16'hAABC, "R8");

    // R11 idle bus and address bit 0
    @(negedge clk); cs = 1'b0; we = 1'b1; addr = 7'h08; wdata = 16'h0000; #1;
    chk("R11", rdata, 16'h0000);
    @(negedge clk); we = 1'b0;
    rd(7'h08, pat(8), "R11");
    wr(7'h09, 16'h1234); rd(7'h08, 16'h1234, "R11");

    // R5 bus reset
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    rd(7'h04, 16'h0000, "R5"); rd(7'h20, 16'h0000, "R5");
    rd(7'h24, 16'h0000, "R5"); rd(7'h28, 16'h0000, "R5");
    rd(7'h22, pat('h22), "R5"); rd(7'h08, 16'h1234, "R5");
    rd(7'h0C, pat('h0C) & 16'h007F, "R5"); rd(7'h02, 16'h0001, "R5");
    rd(7'h00, 16'h0001, "R5");

    // R6 bus reset beats write
    wr(7'h04, 16'h0033);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = 7'h04; wdata = 16'h007F; bus_rst = 1'b1;
    @(negedge clk); cs = 1'b0; we = 1'b0; bus_rst = 1'b0;
    rd(7'h04, 16'h0000, "R6");
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = 7'h24; wdata = 16'hBEEF; bus_rst = 1'b1;
    @(negedge clk); cs = 1'b0; we = 1'b0; bus_rst = 1'b0;
    rd(7'h24, 16'h0000, "R6");

    // R2 hardware reset precedence
    @(negedge clk); hw_rst = 1'b1; bus_rst = 1'b1; cs = 1'b1; we = 1'b1;
    addr = 7'h0C; wdata = 16'h007F;
    @(negedge clk); hw_rst = 1'b0; bus_rst = 1'b0; cs = 1'b0; we = 1'b0;
    rd(7'h0C, 16'h0008, "R2"); rd(7'h00, 16'h0000, "R2");
    rd(7'h22, 16'h0040, "R2"); rd(7'h08, 16'h0000, "R2");
    chk("R2", {15'b0, usb_en}, 16'h0000);

    // R3 transition into software reset, R4 survivors
    wr(7'h00, 16'h0001); wr(7'h02, 16'h0001); wr(7'h08, 16'hABCD);
    wr(7'h0E, 16'h0FFF); wr(7'h0C, 16'h0011); wr(7'h26, 16'h7777);
    rd(7'h08, 16'hABCD, "R12");
    wr(7'h00, 16'h0000);
    @(negedge clk);
    rd(7'h08, 16'h0000, "R3"); rd(7'h02, 16'h0000, "R3");
    rd(7'h0E, 16'hA800, "R3"); rd(7'h00, 16'h0000, "R3");
    rd(7'h0C, 16'h0011, "R4"); rd(7'h26, 16'h7777, "R4");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule